// File: doc/BRIEF.md
# Configuration ROM CRC validator

This block checks the integrity of a configuration ROM image before its contents are trusted. After a `start` pulse it requests the image one 16-bit word at a time. It presents the wanted word index on `word_idx` and takes each word over a valid/ready stream. Over the image it computes an 8-bit CRC with the polynomial x^8+x^7+x^6+x^4+x^2+1. It then compares the result with the check byte that the image stores in its final word. When the scan ends it pulses `done` and reports a pass or corrupt verdict together with the image's revision byte.

Images come in two sizes. The first scan always uses the short length. If that scan fails and the word at a fixed signature position holds 16'h5372, the block assumes a long-format image. It then rescans from index 0 at the long length. The verdict of that second scan is final.

The stream is consumer-paced. `in_ready` is high for exactly as long as a scan is in progress, and the block never stalls a scan. The source may hold `in_valid` low on any cycle, and nothing in the block changes while it does. `word_idx` only moves on a handshake. The source must therefore present the word at the address shown on `word_idx` whenever it raises `in_valid`.

Top module: `cfgrom_crc_check`

## Requirements
- R1: The CRC uses the reflected form of x^8+x^7+x^6+x^4+x^2+1 (right shift, XOR 8'hAB when the bit shifted out is 1) with the register preset to 8'hFF. Every word before the last is fed low byte first, then high byte. The last word feeds only its low byte, and the result is then XORed with 8'hFF.
- R2: The final CRC is compared with bits [15:8] of the last word. On a match `pass`=1 and `corrupt`=0, otherwise `pass`=0 and `corrupt`=1. The two are never high together.
- R3: `revision` is bits [7:0] of the last word of the final scan, reported on both pass and fail.
- R4: A short scan fails and the word at index SIG_IDX equals 16'h5372. The block then restarts at index 0 with the long length, and `long_used`=1 in the result.
- R5: A short scan passes, or the signature is absent. No rescan takes place, `long_used`=0, and a failure is reported as corrupt.
- R6: `in_ready` is high only while scanning. `word_idx` starts at 0, holds while `in_valid` is low and advances by one per handshake. A scan takes exactly the scan length in handshakes, or both lengths summed when it rescans.
- R7: `done` is a one-cycle pulse in the cycle after the final handshake. `pass`, `corrupt`, `revision` and `long_used` then hold until the next accepted start, which clears them to 0.
- R8: A `start` that arrives while a scan is running is ignored.
- R9: After reset `in_ready`, `done`, `pass`, `corrupt`, `long_used`, `revision` and `word_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| in_valid | input | 1 | Source holds the word at `word_idx` |
| in_ready | output | 1 | Block accepts a word (scan in progress) |
| in_word | input | 16 | Image word for the current index |
| word_idx | output | $clog2(LONG_WORDS) | Index of the word wanted next |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | CRC matched |
| corrupt | output | 1 | CRC mismatched on the final scan |
| revision | output | 8 | Low byte of the final scan's last word |
| long_used | output | 1 | Result comes from the long-length rescan |

## Verification
The bench builds the block with SHORT_WORDS=16, LONG_WORDS=40 and SIG_IDX=6 rather than the full-size defaults. A complete scan with a rescan therefore costs only about 56 handshakes. This allows dozens of random images, each of them long-format, short-format, sealed or damaged, under random source stalls. The signature position lies well inside the short image, so the rescan path and its interaction with the short last word are reached on every long-format case.

// File: rtl/cfgrom_crc_pkg.sv
package cfgrom_crc_pkg;
  // Reflected form of x^8+x^7+x^6+x^4+x^2+1
  localparam logic [7:0] CRC_POLY_REFL = 8'hAB;
  localparam logic [7:0] CRC_PRESET    = 8'hFF;
  localparam logic [7:0] CRC_XOR_OUT   = 8'hFF;
  localparam int         WORD_BYTES    = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/cfgrom_crc_byte.sv
module cfgrom_crc_byte
  import cfgrom_crc_pkg::*;
(
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);
  logic [7:0] stage [0:8];

  assign stage[0] = crc_in ^ data_in;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ CRC_POLY_REFL)
                                    : (stage[b] >> 1);
  end

  assign crc_out = stage[8];
endmodule

// File: rtl/cfgrom_crc_word.sv
module cfgrom_crc_word
  import cfgrom_crc_pkg::*;
#(
  parameter int LANES = WORD_BYTES
) (
  input  logic [7:0]         crc_in,
  input  logic [8*LANES-1:0] word_in,
  output logic [7:0]         crc_low,
  output logic [7:0]         crc_full
);
  logic [7:0] chain [0:LANES];

  assign chain[0] = crc_in;

  // Low byte enters first, higher lanes follow in order
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cfgrom_crc_byte u_byte (
      .crc_in  (chain[l]),
      .data_in (word_in[8*l +: 8]),
      .crc_out (chain[l+1])
    );
  end

  assign crc_low  = chain[1];
  assign crc_full = chain[LANES];
endmodule

// File: rtl/cfgrom_crc_seq.sv
module cfgrom_crc_seq
  import cfgrom_crc_pkg::*;
#(
  parameter int          SHORT_WORDS = 64,
  parameter int          LONG_WORDS  = 220,
  parameter int          SIG_IDX     = 32,
  parameter logic [15:0] SIG_WORD    = 16'h5372,
  localparam int         IW          = $clog2(LONG_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hs,
  input  logic [15:0]   word_in,
  input  logic          last_ok,
  output logic          scanning,
  output logic [IW-1:0] idx,
  output logic          is_last,
  output logic          long_mode,
  output logic          start_go,
  output logic          retry,
  output logic          finish
);
  localparam logic [IW-1:0] SHORT_LAST = IW'(SHORT_WORDS - 1);
  localparam logic [IW-1:0] LONG_LAST  = IW'(LONG_WORDS - 1);
  localparam logic [IW-1:0] SIG_POS    = IW'(SIG_IDX);

  scan_state_t state;
  logic        sig_seen;
  logic        sig_now;

  assign scanning = (state == ST_SCAN);
  assign is_last  = idx == (long_mode ? LONG_LAST : SHORT_LAST);
  assign start_go = start && (state == ST_IDLE);
  assign sig_now  = hs && !long_mode && (idx == SIG_POS) && (word_in == SIG_WORD);
  assign retry    = hs && is_last && !last_ok && !long_mode && (sig_seen || sig_now);
  assign finish   = hs && is_last && !retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      long_mode <= 1'b0;
      sig_seen  <= 1'b0;
    end else if (start_go) begin
      state     <= ST_SCAN;
      idx       <= '0;
      long_mode <= 1'b0;
      sig_seen  <= 1'b0;
    end else if (scanning && hs) begin
      if (sig_now) sig_seen <= 1'b1;
      if (retry) begin
        idx       <= '0;
        long_mode <= 1'b1;
      end else if (finish) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgrom_crc_check.sv
module cfgrom_crc_check
  import cfgrom_crc_pkg::*;
#(
  parameter int          SHORT_WORDS = 64,
  parameter int          LONG_WORDS  = 220,
  parameter int          SIG_IDX     = 32,
  parameter logic [15:0] SIG_WORD    = 16'h5372,
  localparam int         IW          = $clog2(LONG_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_word,
  output logic [IW-1:0] word_idx,
  output logic          done,
  output logic          pass,
  output logic          corrupt,
  output logic [7:0]    revision,
  output logic          long_used
);
  logic       hs, is_last, long_mode, start_go, retry, finish, last_ok;
  logic [7:0] crc_q, crc_low, crc_full;

  assign hs      = in_valid && in_ready;
  assign last_ok = (crc_low ^ CRC_XOR_OUT) == in_word[15:8];

  cfgrom_crc_word #(.LANES(WORD_BYTES)) u_word (
    .crc_in   (crc_q),
    .word_in  (in_word),
    .crc_low  (crc_low),
    .crc_full (crc_full)
  );

  cfgrom_crc_seq #(
    .SHORT_WORDS (SHORT_WORDS),
    .LONG_WORDS  (LONG_WORDS),
    .SIG_IDX     (SIG_IDX),
    .SIG_WORD    (SIG_WORD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hs        (hs),
    .word_in   (in_word),
    .last_ok   (last_ok),
    .scanning  (in_ready),
    .idx       (word_idx),
    .is_last   (is_last),
    .long_mode (long_mode),
    .start_go  (start_go),
    .retry     (retry),
    .finish    (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (start_go || retry) begin
      crc_q <= CRC_PRESET;
    end else if (hs && !is_last) begin
      crc_q <= crc_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      corrupt   <= 1'b0;
      revision  <= '0;
      long_used <= 1'b0;
    end else begin
      done <= finish;
      if (start_go) begin
        pass      <= 1'b0;
        corrupt   <= 1'b0;
        revision  <= '0;
        long_used <= 1'b0;
      end else if (finish) begin
        pass      <= last_ok;
        corrupt   <= !last_ok;
        revision  <= in_word[7:0];
        long_used <= long_mode;
      end
    end
  end
endmodule

// File: rtl/cfgrom_crc_check_sva.sv
module cfgrom_crc_check_sva #(
  parameter int  LONG_WORDS = 220,
  localparam int IW         = $clog2(LONG_WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_valid,
  input logic          in_ready,
  input logic [IW-1:0] word_idx,
  input logic          done,
  input logic          pass,
  input logic          corrupt,
  input logic [7:0]    revision,
  input logic          long_used
);
  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(word_idx));
  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !start) |=> !in_ready);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !start) |=> ($stable(pass) && $stable(corrupt) && $stable(revision) && $stable(long_used)));
  // R2
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, corrupt}));
  // R2
  verdict_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ corrupt));
  // R4
  long_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_used) |-> done);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && start && !in_valid) |=> (in_ready && $stable(word_idx)));
endmodule

bind cfgrom_crc_check cfgrom_crc_check_sva #(.LONG_WORDS(LONG_WORDS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .word_idx  (word_idx),
  .done      (done),
  .pass      (pass),
  .corrupt   (corrupt),
  .revision  (revision),
  .long_used (long_used)
);

// File: tb/cfgrom_crc_check_test.sv
`timescale 1ns/1ps
module cfgrom_crc_check_test;
  localparam int SHORT_W = 16;
  localparam int LONG_W  = 40;
  localparam int SIG_AT  = 6;
  localparam int IW      = $clog2(LONG_W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_word = 16'h0;
  logic          in_ready, done, pass, corrupt, long_used;
  logic [7:0]    revision;
  logic [IW-1:0] word_idx;

  int checks = 0;
  int fails = 0;
  int valid_pct = 100;
  logic [15:0] img [0:LONG_W-1];

  always #2.5 clk = ~clk;

  cfgrom_crc_check #(
    .SHORT_WORDS (SHORT_W),
    .LONG_WORDS  (LONG_W),
    .SIG_IDX     (SIG_AT)
  ) uut (
    .clk, .rst_n, .start, .in_valid, .in_ready, .in_word, .word_idx,
    .done, .pass, .corrupt, .revision, .long_used
  );

  // Source: presents the addressed word, with random stalls
  always @(negedge clk) begin
    in_valid <= rst_n && (($urandom % 100) < valid_pct);
    in_word  <= (int'(word_idx) < LONG_W) ? img[word_idx] : 16'h0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 8'hAB) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] model(input int len);
    logic [7:0] c = 8'hFF;
    for (int w = 0; w < len - 1; w++) begin
      c = step(c, img[w][7:0]);
      c = step(c, img[w][15:8]);
    end
    c = step(c, img[len-1][7:0]);
    return c ^ 8'hFF;
  endfunction

  task automatic seal(input int len);
    img[len-1][15:8] = model(len);
  endtask

  task automatic build(input int kind);
    for (int i = 0; i < LONG_W; i++) img[i] = 16'($urandom);
    if (kind <= 1) begin
      if (img[SIG_AT] == 16'h5372) img[SIG_AT] = 16'h5373;
    end else begin
      img[SIG_AT] = 16'h5372;
    end
    seal(SHORT_W);
    if (kind == 1) img[SHORT_W-1][15:8] ^= 8'(1 + ($urandom % 255));
    if (kind == 2 || kind == 3) begin
      img[SHORT_W-1][15:8] ^= 8'h3C;
      seal(LONG_W);
      if (kind == 3) img[LONG_W-1][15:8] ^= 8'h81;
    end
  endtask

  task automatic run_scan(input string req, input bit poke);
    bit ok_s, sig, exp_long, exp_pass;
    logic [7:0] exp_rev;
    logic [IW-1:0] seen;
    int exp_hs, hs, cyc;
    bit poked;
    ok_s = model(SHORT_W) == img[SHORT_W-1][15:8];
    sig  = img[SIG_AT] == 16'h5372;
    if (ok_s || !sig) begin
      exp_long = 0; exp_pass = ok_s; exp_rev = img[SHORT_W-1][7:0]; exp_hs = SHORT_W;
    end else begin
      exp_long = 1; exp_pass = model(LONG_W) == img[LONG_W-1][15:8];
      exp_rev = img[LONG_W-1][7:0]; exp_hs = SHORT_W + LONG_W;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1;
    // R7: accepted start clears results and starts scanning at index 0
    chk(in_ready && !pass && !corrupt && !long_used && word_idx == 0, "R7",
        "start clears results", {pass, corrupt, long_used}, 0);
    hs = 0; cyc = 0; poked = 0;
    forever begin
      if (poked) begin
        start = 1'b0; poked = 0;
        #1;
        // R8: start while busy does not restart the scan
        chk(word_idx == seen + 1'b1, "R8", "idx after busy start", word_idx, seen + 1'b1);
      end else begin
        #1;
      end
      if (done) break;
      if (in_valid && in_ready) hs++;
      if (poke && cyc == 4) begin
        seen = word_idx; start = 1'b1; poked = 1;
      end
      cyc++;
      if (cyc > 5000) begin
        chk(0, "R6", "scan watchdog", cyc, exp_hs);
        return;
      end
      @(negedge clk);
    end
    chk(pass == exp_pass, req, "pass", pass, exp_pass);
    // R2
    chk(corrupt == !exp_pass, "R2", "corrupt", corrupt, !exp_pass);
    // R3
    chk(revision == exp_rev, "R3", "revision", revision, exp_rev);
    chk(long_used == exp_long, exp_long ? "R4" : "R5", "long_used", long_used, exp_long);
    // R6
    chk(hs == exp_hs, "R6", "handshake count", hs, exp_hs);
    @(negedge clk); #1;
    // R7
    chk(!done && !in_ready && pass == exp_pass && revision == exp_rev, "R7",
        "done pulse width / hold", done, 0);
  endtask

  initial begin
    #400000;
    chk(0, "R6", "global watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < LONG_W; i++) img[i] = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    // R9
    chk(!in_ready && !done && !pass && !corrupt && !long_used && revision == 0 && word_idx == 0,
        "R9", "reset state", {in_ready, done, pass, corrupt, long_used}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: sealed all-zero and all-ones images
    for (int i = 0; i < LONG_W; i++) img[i] = 16'h0;
    seal(SHORT_W);
    run_scan("R1", 0);
    for (int i = 0; i < LONG_W; i++) img[i] = 16'hFFFF;
    seal(SHORT_W);
    run_scan("R1", 0);
    // R1: known byte step of the reflected polynomial
    chk(step(8'h00, 8'h01) == 8'hF7, "R1", "model vector", step(8'h00, 8'h01), 8'hF7);

    build(0); run_scan("R1", 0);
    build(1); run_scan("R5", 0);
    build(2); run_scan("R4", 0);
    build(3); run_scan("R4", 0);
    build(4); run_scan("R5", 0);
    // R8: busy start during a scan with a steady source
    build(2); run_scan("R8", 1);

    valid_pct = 60;
    for (int n = 0; n < 40; n++) begin
      int k = $urandom % 5;
      build(k);
      run_scan(k == 0 || k == 4 ? "R1" : (k == 1 ? "R5" : "R4"), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule